// File: doc/BRIEF.md
# Serial Memory Write Guard and Status Register

This block holds the status byte of a small serial memory and decides, for each array write or status write, whether it may go ahead. It keeps a write-enable latch, a two-bit block-protect field and a write-busy flag. The serial front end raises a one-cycle `frame_end_i` pulse when chip select rises. With that pulse it hands over the instruction byte, the number of bits clocked in during the frame, the start address and the first data byte. A separate level input carries the hardware write-protect pin, where high means writes are allowed.

For every write or status-write frame the block answers one cycle later with exactly one of a grant pulse or a deny pulse. A grant starts an internal write cycle of `WRITE_CYCLES` clocks. During that cycle the busy flag is set and the memory core does the programming. The status byte is always available on `status_o` for the front end to shift out on a status read. The non-volatile protect field is modelled as a register with a reset default.

Top module: `wprot_ctrl`

## Requirements
- R1: `status_o` carries the busy flag in bit 0, the enable latch in bit 1, protect bit P0 in bit 2 and protect bit P1 in bit 3. Bits 7 to 4 read as zero.
- R2: After reset the latch is 0, the busy flag is 0 and {P1,P0} = 01, so `status_o` = 0x04.
- R3: An instruction byte is recognised only when bits 7:4 are zero. Bit 3 is ignored. Bits 2:0 select the command: 110 set latch, 100 clear latch, 010 array write, 001 status write. Codes 011 and 101 are reads and have no effect here. Any other byte is ignored.
- R4: A set-latch frame sets the latch only when it holds exactly 8 bits. A clear-latch frame clears it only when it holds exactly 8 bits. Both act whatever the protect field and the busy flag hold.
- R5: While the protect pin is low, the latch is cleared at the next clock edge and held at 0, and every write and status write is denied.
- R6: {P1,P0} = 00 protects no address, 01 protects C0h–FFh, 10 protects 80h–FFh and 11 protects every address. An array write is judged on its start address.
- R7: Every array-write or status-write frame gives exactly one of `grant_o` or `deny_o` for one cycle, in the cycle after `frame_end_i`. An array write is granted only if all of these hold: the latch is 1, the pin is high, the block is not busy, the bit count is at least 24 and a multiple of 8, and the address is unprotected.
- R8: A status write is granted only if the latch is 1, the pin is high, the block is not busy and the frame holds exactly 16 bits. It then loads {P1,P0} from data bits 3:2, even when the field currently protects all addresses.
- R9: A grant clears the latch. It also sets the busy flag for exactly `WRITE_CYCLES` cycles, starting in the cycle the grant is visible.
- R10: The protect pin going low during a running write cycle does not shorten the busy period.
- R11: A denied request leaves the busy flag and the protect field unchanged. It leaves the latch unchanged unless the pin is low.
- R12: While busy, array writes and status writes are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_end_i | input | 1 | One-cycle pulse: a frame closed with chip select rising |
| frame_op_i | input | 8 | Instruction byte of the frame |
| frame_bits_i | input | BITS_W | Number of bits clocked in during the frame |
| frame_addr_i | input | ADDR_W | Start address of an array write |
| frame_data_i | input | 8 | First data byte (status value for a status write) |
| hw_wr_allow_i | input | 1 | Write-protect pin level, high allows writes |
| grant_o | output | 1 | Pulse: the write was accepted and a write cycle starts |
| deny_o | output | 1 | Pulse: the write was refused |
| status_o | output | 8 | Status byte |

## Verification
The bench targets four kinds of corner case:
- Bit counts one short of and one past the required value, for set-latch frames, status writes and array writes. A design that only counted whole bytes, or that accepted a trailing partial byte, would set the latch or grant a write on those frames.
- Addresses on each side of the C0h and 80h protection edges, under every protect setting. A wrong decode grants a write into the protected quarter, or refuses one just below it.
- The protect pin dropping inside a running cycle. A design that tied the cycle to the pin would drop the busy flag early.
- Requests arriving while busy. A design that let these through would restart the cycle and extend the busy period.

// File: rtl/wprot_pkg.sv
// Shared types for the write guard: command kinds and the instruction decoder.
// Assumes the instruction byte is delivered whole by the serial front end.
package wprot_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_READ,
        OPK_WRITE,
        OPK_CLR_EN,
        OPK_SET_EN,
        OPK_RD_STAT,
        OPK_WR_STAT
    } op_kind_e;

    // Map an instruction byte to a command kind; bit 3 is a don't-care.
    function automatic op_kind_e decode_op(input logic [7:0] b);
        op_kind_e k;
        k = OPK_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b011:  k = OPK_READ;
                3'b010:  k = OPK_WRITE;
                3'b100:  k = OPK_CLR_EN;
                3'b110:  k = OPK_SET_EN;
                3'b101:  k = OPK_RD_STAT;
                3'b001:  k = OPK_WR_STAT;
                default: k = OPK_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/wprot_region_guard.sv
// Combinational decode of the protect field against an address.
// Protected windows are the top quarter, top half or the whole space,
// so ADDR_W must be at least 2.
module wprot_region_guard #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bp_i,
    output logic              locked_o
);

    logic top_half;
    logic top_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign top_half    = addr_i[ADDR_W-1];
            assign top_quarter = &addr_i[ADDR_W-1 -: 2];
        end else begin : g_narrow
            assign top_half    = addr_i[0];
            assign top_quarter = addr_i[0];
        end
    endgenerate

    // Select the protected window from the two-bit field.
    always_comb begin
        case (bp_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = top_quarter;
            2'b10:   locked_o = top_half;
            default: locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wprot_enable_latch.sv
// Write-enable latch. The pin low wins over everything; a clear request wins
// over a set request. Assumes requests are single-cycle pulses.
module wprot_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic pin_ok_i,
    output logic wel_o
);

    // Update the latch from pin level and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)          wel_o <= 1'b0;
        else if (!pin_ok_i)  wel_o <= 1'b0;
        else if (clr_i)      wel_o <= 1'b0;
        else if (set_i)      wel_o <= 1'b1;
    end

    p_pin_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_ok_i |=> !wel_o);

    p_set_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && pin_ok_i && !clr_i) |=> wel_o);

    p_clr_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !wel_o);

endmodule

// File: rtl/wprot_cycle_timer.sv
// Internal write-cycle timer: busy for CYCLES clocks after a start pulse.
// Assumes start is never raised while busy; the pin does not reach here.
module wprot_cycle_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (start_i)       cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));

    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    p_runs_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > 1 && !start_i) |=> busy_o);

endmodule

// File: rtl/wprot_ctrl.sv
// Status register and write guard for a serial memory. Judges each closed
// frame from the front end, keeps the enable latch, protect field and busy
// flag, and returns grant/deny one cycle after the frame closes.
// Assumes frame_end_i is a one-cycle pulse per chip-select rise.
module wprot_ctrl #(
    parameter int ADDR_W       = 8,
    parameter int BITS_W       = 12,
    parameter int WRITE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic [7:0]        frame_op_i,
    input  logic [BITS_W-1:0] frame_bits_i,
    input  logic [ADDR_W-1:0] frame_addr_i,
    input  logic [7:0]        frame_data_i,
    input  logic              hw_wr_allow_i,
    output logic              grant_o,
    output logic              deny_o,
    output logic [7:0]        status_o
);
    import wprot_pkg::*;

    localparam logic [BITS_W-1:0] ONE_BYTE  = BITS_W'(8);
    localparam logic [BITS_W-1:0] TWO_BYTES = BITS_W'(16);
    localparam logic [BITS_W-1:0] MIN_WRITE = BITS_W'(24);
    localparam logic [1:0]        BP_RESET  = 2'b01;

    op_kind_e   op;
    logic       len_one, len_two, len_write;
    logic       set_req, clr_req, wr_req, allow;
    logic       grant_d, deny_d;
    logic       wel, busy, locked;
    logic [1:0] bp_q;

    // Classify the closing frame.
    always_comb begin
        op        = decode_op(frame_op_i);
        len_one   = (frame_bits_i == ONE_BYTE);
        len_two   = (frame_bits_i == TWO_BYTES);
        len_write = (frame_bits_i >= MIN_WRITE) && (frame_bits_i[2:0] == 3'b000);
        set_req   = frame_end_i && (op == OPK_SET_EN) && len_one;
        clr_req   = frame_end_i && (op == OPK_CLR_EN) && len_one;
        wr_req    = frame_end_i && ((op == OPK_WRITE) || (op == OPK_WR_STAT));
    end

    // Decide whether a write or status write may proceed.
    always_comb begin
        allow = wel && hw_wr_allow_i && !busy;
        if (op == OPK_WRITE) allow = allow && len_write && !locked;
        else                 allow = allow && len_two;
        grant_d = wr_req && allow;
        deny_d  = wr_req && !allow;
    end

    wprot_region_guard #(.ADDR_W(ADDR_W)) u_guard (
        .addr_i   (frame_addr_i),
        .bp_i     (bp_q),
        .locked_o (locked)
    );

    wprot_enable_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_req),
        .clr_i    (clr_req || grant_d),
        .pin_ok_i (hw_wr_allow_i),
        .wel_o    (wel)
    );

    wprot_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (grant_d),
        .busy_o  (busy)
    );

    // Register the verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= grant_d;
            deny_o  <= deny_d;
        end
    end

    // Protect field: reset default, loaded by a granted status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bp_q <= BP_RESET;
        else if (grant_d && (op == OPK_WR_STAT))
            bp_q <= frame_data_i[3:2];
    end

    assign status_o = {4'b0000, bp_q, wel, busy};

    p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    p_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> status_o[0]);

    p_grant_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> $past(hw_wr_allow_i));

    p_grant_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && $past(op == OPK_WRITE)) |-> !$past(locked));

    p_deny_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_o && !$past(busy)) |-> !status_o[0]);

    p_deny_keeps_bp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> $stable(bp_q));

    p_hi_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:4] == 4'h0);

endmodule

// File: tb/wprot_ctrl_bench.sv
`timescale 1ns/1ps
module wprot_ctrl_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe = 1'b0;
    logic [7:0]  fop = 8'h00;
    logic [11:0] fbits = 12'd0;
    logic [7:0]  faddr = 8'h00;
    logic [7:0]  fdata = 8'h00;
    logic        wp = 1'b1;
    logic        grant, deny;
    logic [7:0]  stat;

    int checks = 0;
    int fails  = 0;

    bit       m_wel = 1'b0;
    bit [1:0] m_bp  = 2'b01;
    int       m_left = 0;

    always #2 clk = ~clk;

    wprot_ctrl #(.ADDR_W(8), .BITS_W(12), .WRITE_CYCLES(N)) u_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_end_i(fe), .frame_op_i(fop),
        .frame_bits_i(fbits), .frame_addr_i(faddr), .frame_data_i(fdata),
        .hw_wr_allow_i(wp), .grant_o(grant), .deny_o(deny), .status_o(stat)
    );

    function automatic bit prot(input bit [1:0] bp, input bit [7:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 8'hC0;
            2'b10:   return a >= 8'h80;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock with an optional frame; model predicts, then outputs are compared.
    task automatic step(input bit en, input bit [7:0] op, input int bits,
                        input bit [7:0] addr, input bit [7:0] data,
                        input bit pin, input string tag);
        bit eg, ed, busy, valid, wr;
        bit [2:0] c;
        fe = en; fop = op; fbits = 12'(bits); faddr = addr; fdata = data; wp = pin;
        eg = 0; ed = 0;
        busy = (m_left != 0);
        if (busy) m_left--;
        valid = (op[7:4] == 4'h0);
        c = op[2:0];
        if (en && valid) begin
            if (c == 3'b110 && bits == 8) m_wel = 1;
            if (c == 3'b100 && bits == 8) m_wel = 0;
            if (c == 3'b010) begin
                wr = m_wel && pin && !busy && bits >= 24 && (bits % 8 == 0) && !prot(m_bp, addr);
                if (wr) begin eg = 1; m_wel = 0; m_left = N; end else ed = 1;
            end
            if (c == 3'b001) begin
                wr = m_wel && pin && !busy && bits == 16;
                if (wr) begin eg = 1; m_wel = 0; m_left = N; m_bp = data[3:2]; end else ed = 1;
            end
        end
        if (!pin) m_wel = 0;
        @(posedge clk); #1;
        check({tag, " grant"}, {31'd0, grant}, {31'd0, eg});
        check({tag, " deny"}, {31'd0, deny}, {31'd0, ed});
        check({tag, " status"}, {24'd0, stat}, {24'd0, 4'h0, m_bp, m_wel, m_left != 0});
        @(negedge clk);
        fe = 0;
    endtask

    task automatic idle(input int n, input bit pin, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 8'h00, pin, tag);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails + 1 - 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state, R1 layout
        idle(1, 1, "R2");
        check("R1 upper nibble", {24'd0, stat[7:4]}, 0);
        // R4 set latch: 7 and 9 bits ignored, 8 bits sets
        step(1, 8'h06, 7, 0, 0, 1, "R4 short");
        step(1, 8'h06, 9, 0, 0, 1, "R4 long");
        step(1, 8'h06, 8, 0, 0, 1, "R4 set");
        // R3 bit3 ignored, upper nibble non-zero ignored
        step(1, 8'h04, 8, 0, 0, 1, "R4 clear");
        step(1, 8'h0E, 8, 0, 0, 1, "R3 bit3");
        step(1, 8'h14, 8, 0, 0, 1, "R3 nibble");
        step(1, 8'h03, 8, 0, 0, 1, "R3 read");
        // R6 quarter protected: C0 denied, R11 latch kept
        step(1, 8'h02, 24, 8'hC0, 0, 1, "R6 C0");
        step(1, 8'h02, 30, 8'h10, 0, 1, "R7 partial");
        // R7 grant at BF, R9 busy window
        step(1, 8'h02, 32, 8'hBF, 0, 1, "R7 BF");
        step(1, 8'h06, 8, 0, 0, 1, "R12 set while busy");
        step(1, 8'h01, 16, 0, 8'h00, 1, "R12 wrsr busy");
        idle(3, 0, "R10 pin low");
        idle(N, 1, "R9 window");
        // R5 pin low blocks
        step(1, 8'h06, 8, 0, 0, 0, "R5 set pin low");
        step(1, 8'h06, 8, 0, 0, 1, "R5 set");
        step(1, 8'h02, 24, 8'h00, 0, 0, "R5 write pin low");
        // R8 status write to 10 then edges
        step(1, 8'h06, 8, 0, 0, 1, "R8 set");
        step(1, 8'h01, 17, 0, 8'h08, 1, "R8 17 bits");
        step(1, 8'h01, 16, 0, 8'h08, 1, "R8 wrsr");
        idle(N, 1, "R9 wait");
        step(1, 8'h06, 8, 0, 0, 1, "R6 set");
        step(1, 8'h02, 24, 8'h80, 0, 1, "R6 80");
        step(1, 8'h02, 24, 8'h7F, 0, 1, "R6 7F");
        idle(N, 1, "R9 wait");
        step(1, 8'h06, 8, 0, 0, 1, "R8 set");
        step(1, 8'h01, 16, 0, 8'h0C, 1, "R8 all");
        idle(N, 1, "R9 wait");
        step(1, 8'h06, 8, 0, 0, 1, "R6 set");
        step(1, 8'h02, 24, 8'h00, 0, 1, "R6 all 00");
        step(1, 8'h01, 16, 0, 8'h00, 1, "R8 from all");
        idle(N, 1, "R9 wait");
        // constrained random
        void'($urandom(32'h5EED1));
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] ops [8] = '{8'h06, 8'h04, 8'h02, 8'h01, 8'h03, 8'h05, 8'h0A, 8'h26};
            int lens [8] = '{7, 8, 9, 16, 24, 32, 27, 40};
            bit en = ($urandom % 10) < 4;
            step(en, ops[$urandom % 8], lens[$urandom % 8], 8'($urandom),
                 8'($urandom), ($urandom % 10) != 0, "R7 random");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule